// File: doc/BRIEF.md
# Weighted-Cost Inversion Write Encoder

This block prepares one memory row for writing into a cell technology whose write cost depends on the transition a cell makes. It takes the value currently held in the row, the new data, the stored inversion flag and four programmable costs, one per transition kind: 0 to 1, 1 to 0, 0 to 0 and 1 to 1. It adds up the cost of writing the data as given and the cost of writing its complement. Each sum includes the cost of moving the flag cell to its new value. The cheaper form is written.

The result is the row to store, the new flag bit and both cost totals. Reading the row back means XORing every stored bit with the flag. Requests enter on a valid/ready handshake, and the result is held in an output register until the consumer takes it. Typical settings are 1/2/0/0 for a write-endurance-limited resistive cell and 1/0/0/0 for a magnetic cell whose 0-to-1 write is error prone.

Top module: `inv_write_enc`

## Requirements
- R1: `cost_plain_o` equals the sum, over every data cell, of the cost of the transition from old bit to new bit, plus the cost of the flag cell moving from `old_flag_i` to 0.
- R2: `cost_inv_o` equals the sum, over every data cell, of the cost of the transition from old bit to the complemented new bit, plus the cost of the flag cell moving from `old_flag_i` to 1.
- R3: The totals never wrap. With every cost at 15 and the default 32-bit row, both totals read 495.
- R4: `enc_flag_o` is 1 exactly when `cost_inv_o` is strictly less than `cost_plain_o`. This includes a difference of one.
- R5: When the two totals are equal, `enc_flag_o` is 0 and the row is stored unmodified.
- R6: `enc_row_o` equals the accepted new data XORed bitwise with `enc_flag_o`.
- R7: A request is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. Its result appears with `out_valid_o` high right after that edge.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low and every output holds its value.
- R9: While `out_ready_i` is high, `in_ready_o` is high. A result that is drained at an edge can be replaced by a new request accepted at the same edge.
- R10: While `rst_ni` is low, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken |
| old_row_i | input | DATA_W | Row value currently stored |
| old_flag_i | input | 1 | Inversion flag currently stored |
| new_row_i | input | DATA_W | Data to be written |
| cost_01_i | input | COST_W | Cost of a 0-to-1 cell write |
| cost_10_i | input | COST_W | Cost of a 1-to-0 cell write |
| cost_00_i | input | COST_W | Cost of a cell staying 0 |
| cost_11_i | input | COST_W | Cost of a cell staying 1 |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| enc_row_o | output | DATA_W | Row to store |
| enc_flag_o | output | 1 | New inversion flag |
| cost_plain_o | output | SUM_W | Total cost of the unmodified form |
| cost_inv_o | output | SUM_W | Total cost of the complemented form |

## Verification
Draining a held result and loading a new request can occur at the same clock edge. The bench sets up this case by stalling the consumer with a pending request waiting, then raising `out_ready_i`. After that edge it checks that the first result has been replaced by the second request's own encoding and totals, and that no stale value remains. The cost decision is checked separately on a set of directed rows that hit exact ties, a gain of one, and saturated costs. It is also checked on random rows under four cost profiles against a brute-force sum.

// File: rtl/inv_enc_pkg.sv
package inv_enc_pkg;

  typedef enum logic [1:0] {
    TR_00 = 2'b00,
    TR_01 = 2'b01,
    TR_10 = 2'b10,
    TR_11 = 2'b11
  } trans_e;

  function automatic trans_e classify(input logic old_b, input logic new_b);
    return trans_e'({old_b, new_b});
  endfunction

endpackage

// File: rtl/inv_cell_cost.sv
module inv_cell_cost
  import inv_enc_pkg::*;
#(
  parameter int COST_W = 4
) (
  input  logic              old_i,
  input  logic              new_i,
  input  logic [COST_W-1:0] c01_i,
  input  logic [COST_W-1:0] c10_i,
  input  logic [COST_W-1:0] c00_i,
  input  logic [COST_W-1:0] c11_i,
  output logic [COST_W-1:0] plain_o,
  output logic [COST_W-1:0] inv_o
);

  function automatic logic [COST_W-1:0] pick(input trans_e t,
      input logic [COST_W-1:0] a, input logic [COST_W-1:0] b,
      input logic [COST_W-1:0] c, input logic [COST_W-1:0] d);
    unique case (t)
      TR_01:   return a;
      TR_10:   return b;
      TR_00:   return c;
      default: return d;
    endcase
  endfunction

  always_comb begin
    plain_o = pick(classify(old_i, new_i), c01_i, c10_i, c00_i, c11_i);
    inv_o   = pick(classify(old_i, ~new_i), c01_i, c10_i, c00_i, c11_i);
  end

endmodule

// File: rtl/inv_cost_sum.sv
module inv_cost_sum #(
  parameter int N      = 33,
  parameter int COST_W = 4,
  parameter int SUM_W  = 10
) (
  input  logic [N*COST_W-1:0] costs_i,
  output logic [SUM_W-1:0]    sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + SUM_W'(costs_i[i*COST_W +: COST_W]);
    end
  end

endmodule

// File: rtl/inv_enc_decide.sv
module inv_enc_decide #(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 10
) (
  input  logic [SUM_W-1:0]  plain_i,
  input  logic [SUM_W-1:0]  inv_i,
  input  logic [DATA_W-1:0] new_row_i,
  output logic              invert_o,
  output logic [DATA_W-1:0] row_o
);

  // strict compare: ties keep the unmodified form
  always_comb begin
    invert_o = inv_i < plain_i;
    row_o    = new_row_i ^ {DATA_W{invert_o}};
  end

endmodule

// File: rtl/inv_write_enc.sv
module inv_write_enc #(
  parameter int DATA_W = 32,
  parameter int COST_W = 4,
  localparam int NCELL = DATA_W + 1,
  localparam int SUM_W = COST_W + $clog2(NCELL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] old_row_i,
  input  logic              old_flag_i,
  input  logic [DATA_W-1:0] new_row_i,
  input  logic [COST_W-1:0] cost_01_i,
  input  logic [COST_W-1:0] cost_10_i,
  input  logic [COST_W-1:0] cost_00_i,
  input  logic [COST_W-1:0] cost_11_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] enc_row_o,
  output logic              enc_flag_o,
  output logic [SUM_W-1:0]  cost_plain_o,
  output logic [SUM_W-1:0]  cost_inv_o
);

  // flag cell sits at the top; its plain target is 0, inverted target 1
  logic [NCELL-1:0]        cell_old;
  logic [NCELL-1:0]        cell_new;
  logic [NCELL*COST_W-1:0] plain_costs;
  logic [NCELL*COST_W-1:0] inv_costs;
  logic [SUM_W-1:0]        sum_plain;
  logic [SUM_W-1:0]        sum_inv;
  logic                    invert;
  logic [DATA_W-1:0]       row_next;
  logic                    accept;
  logic                    valid_q;

  assign cell_old = {old_flag_i, old_row_i};
  assign cell_new = {1'b0, new_row_i};

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    inv_cell_cost #(.COST_W(COST_W)) u_cell (
      .old_i  (cell_old[g]),
      .new_i  (cell_new[g]),
      .c01_i  (cost_01_i),
      .c10_i  (cost_10_i),
      .c00_i  (cost_00_i),
      .c11_i  (cost_11_i),
      .plain_o(plain_costs[g*COST_W +: COST_W]),
      .inv_o  (inv_costs[g*COST_W +: COST_W])
    );
  end

  inv_cost_sum #(.N(NCELL), .COST_W(COST_W), .SUM_W(SUM_W)) u_sum_plain (
    .costs_i(plain_costs),
    .sum_o  (sum_plain)
  );

  inv_cost_sum #(.N(NCELL), .COST_W(COST_W), .SUM_W(SUM_W)) u_sum_inv (
    .costs_i(inv_costs),
    .sum_o  (sum_inv)
  );

  inv_enc_decide #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_decide (
    .plain_i  (sum_plain),
    .inv_i    (sum_inv),
    .new_row_i(new_row_i),
    .invert_o (invert),
    .row_o    (row_next)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      enc_row_o    <= '0;
      enc_flag_o   <= 1'b0;
      cost_plain_o <= '0;
      cost_inv_o   <= '0;
    end else begin
      if (accept) begin
        valid_q      <= 1'b1;
        enc_row_o    <= row_next;
        enc_flag_o   <= invert;
        cost_plain_o <= sum_plain;
        cost_inv_o   <= sum_inv;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;

endmodule

// File: rtl/inv_write_enc_chk.sv
module inv_write_enc_chk #(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] new_row_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] enc_row_o,
  input logic              enc_flag_o,
  input logic [SUM_W-1:0]  cost_plain_o,
  input logic [SUM_W-1:0]  cost_inv_o
);

  p_inv_strict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && enc_flag_o) |-> (cost_inv_o < cost_plain_o));

  p_tie_plain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !enc_flag_o) |-> (cost_plain_o <= cost_inv_o));

  p_decode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> ((enc_row_o ^ {DATA_W{enc_flag_o}}) == $past(new_row_i)));

  p_valid_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(enc_row_o)
      && $stable(enc_flag_o) && $stable(cost_plain_o) && $stable(cost_inv_o)));

endmodule

bind inv_write_enc inv_write_enc_chk #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_chk (.*);

// File: tb/inv_write_enc_test.sv
`timescale 1ns/1ps
module inv_write_enc_test;

  localparam int DW = 32;
  localparam int CW = 4;
  localparam int SW = CW + $clog2(DW + 2);

  typedef struct packed {
    logic [DW-1:0] old_row;
    logic          old_flag;
    logic [DW-1:0] new_row;
    logic [CW-1:0] c01, c10, c00, c11;
    logic          exp_flag;
    logic [SW-1:0] exp_plain;
    logic [SW-1:0] exp_inv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0,        1'b0, 32'hFFFFFFFF, 4'd1, 4'd2, 4'd0, 4'd0, 1'b1, 10'd32,  10'd1},
    '{32'hFFFFFFFF, 1'b0, 32'h0,        4'd1, 4'd2, 4'd0, 4'd0, 1'b1, 10'd64,  10'd1},
    '{32'h0,        1'b0, 32'h0,        4'd1, 4'd2, 4'd0, 4'd0, 1'b0, 10'd0,   10'd33},
    '{32'h0000FFFF, 1'b1, 32'hFFFF0000, 4'd1, 4'd0, 4'd0, 4'd0, 1'b1, 10'd16,  10'd0},
    '{32'h0,        1'b1, 32'h0000FFFF, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0, 10'd16,  10'd16},
    '{32'h0,        1'b0, 32'h12345678, 4'd15,4'd15,4'd15,4'd15,1'b0, 10'd495, 10'd495},
    '{32'h0,        1'b0, 32'h0001FFFF, 4'd1, 4'd1, 4'd0, 4'd0, 1'b1, 10'd17,  10'd16},
    '{32'hF0F0F0F0, 1'b0, 32'hFF00FF00, 4'd1, 4'd2, 4'd0, 4'd0, 1'b0, 10'd24,  10'd25}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [DW-1:0] old_row_i = '0;
  logic          old_flag_i = 1'b0;
  logic [DW-1:0] new_row_i = '0;
  logic [CW-1:0] cost_01_i = '0, cost_10_i = '0, cost_00_i = '0, cost_11_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b1;
  logic [DW-1:0] enc_row_o;
  logic          enc_flag_o;
  logic [SW-1:0] cost_plain_o, cost_inv_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  inv_write_enc #(.DATA_W(DW), .COST_W(CW)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cc(input logic o, input logic n, input vec_t v);
    case ({o, n})
      2'b01:   return v.c01;
      2'b10:   return v.c10;
      2'b00:   return v.c00;
      default: return v.c11;
    endcase
  endfunction

  function automatic vec_t brute(input vec_t v);
    vec_t r = v;
    int p = cc(v.old_flag, 1'b0, v);
    int q = cc(v.old_flag, 1'b1, v);
    for (int i = 0; i < DW; i++) begin
      p += cc(v.old_row[i], v.new_row[i], v);
      q += cc(v.old_row[i], ~v.new_row[i], v);
    end
    r.exp_plain = SW'(p);
    r.exp_inv   = SW'(q);
    r.exp_flag  = q < p;
    return r;
  endfunction

  task automatic drive(input vec_t v);
    old_row_i  = v.old_row;
    old_flag_i = v.old_flag;
    new_row_i  = v.new_row;
    cost_01_i  = v.c01;
    cost_10_i  = v.c10;
    cost_00_i  = v.c00;
    cost_11_i  = v.c11;
  endtask

  task automatic expect_out(input vec_t v, input string tag);
    logic [DW-1:0] er = v.new_row ^ {DW{v.exp_flag}};
    chk(out_valid_o === 1'b1, {tag, " R7 valid"}, 64'(out_valid_o), 64'd1);
    chk(cost_plain_o === v.exp_plain, {tag, " R1 plain"}, 64'(cost_plain_o), 64'(v.exp_plain));
    chk(cost_inv_o === v.exp_inv, {tag, " R2 inv"}, 64'(cost_inv_o), 64'(v.exp_inv));
    chk(enc_flag_o === v.exp_flag, {tag, " R4 R5 flag"}, 64'(enc_flag_o), 64'(v.exp_flag));
    chk(enc_row_o === er, {tag, " R6 row"}, 64'(enc_row_o), 64'(er));
  endtask

  // one request with consumer ready; sampled at the negedge after the accept edge
  task automatic apply(input vec_t v, input string tag);
    @(negedge clk_i);
    drive(v);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    expect_out(v, tag);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t a, b;
    #3;
    chk(out_valid_o === 1'b0, "R10 valid in reset", 64'(out_valid_o), 64'd0);
    chk(in_ready_o === 1'b1, "R10 ready in reset", 64'(in_ready_o), 64'd1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk: R3 saturated costs at index 5, R5 tie at 4, R4 gain of one at 6
    for (int i = 0; i < NV; i++) apply(VEC[i], $sformatf("vec%0d", i));

    // random rows over four cost profiles, checked against brute force (R1 R2 R4)
    for (int i = 0; i < 200; i++) begin
      vec_t v;
      v.old_row  = $urandom;
      v.old_flag = 1'($urandom);
      v.new_row  = $urandom;
      case (i % 4)
        0: {v.c01, v.c10, v.c00, v.c11} = {4'd1, 4'd2, 4'd0, 4'd0};
        1: {v.c01, v.c10, v.c00, v.c11} = {4'd1, 4'd0, 4'd0, 4'd0};
        2: {v.c01, v.c10, v.c00, v.c11} = {4'd1, 4'd1, 4'd0, 4'd0};
        default: {v.c01, v.c10, v.c00, v.c11} = 16'($urandom);
      endcase
      apply(brute(v), $sformatf("rand%0d", i));
    end

    // R8 stall, then R9 drain and accept at one edge
    a = VEC[0];
    b = VEC[7];
    @(negedge clk_i);
    out_ready_i = 1'b0;
    drive(a);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    drive(b);
    chk(in_ready_o === 1'b0, "R8 ready low while stalled", 64'(in_ready_o), 64'd0);
    repeat (2) @(negedge clk_i);
    expect_out(a, "stall R8");
    chk(in_ready_o === 1'b0, "R8 ready still low", 64'(in_ready_o), 64'd0);
    out_ready_i = 1'b1;
    #1;
    chk(in_ready_o === 1'b1, "R9 ready with consumer ready", 64'(in_ready_o), 64'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    expect_out(b, "swap R9");
    @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R9 drained", 64'(out_valid_o), 64'd0);

    // reset mid-run clears the result (R10)
    apply(VEC[1], "pre-reset");
    rst_ni = 1'b0;
    #1;
    chk(out_valid_o === 1'b0, "R10 valid after reset", 64'(out_valid_o), 64'd0);
    chk(in_ready_o === 1'b1, "R10 ready after reset", 64'(in_ready_o), 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule